// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the software-visible side of a simple serial port. A processor reaches it through a single-cycle register port with a 12-bit byte address and a 32-bit data path. The register is picked by the word index, which is the byte address shifted right by two. The stored registers are 16 bits wide and are zero-extended on reads.

The block does not serialise bits. It trades whole characters with a character engine over a byte interface in each direction:

- Toward the transmitter, it raises a strobe for one cycle with the byte.
- From the receiver, it accepts a byte, or a break event, through a valid/ready pair.
- A single-character holding register stands in place of a FIFO on each side.

Status flags report receive-ready and transmit-ready. Some status bits are cleared by writing one to them. A level interrupt combines the status flags with enable bits in control register 1. The FIFO-control, baud and one-millisecond registers only hold values for software to read back.

Top module: `sercon_regs`

## Requirements
- R1: After reset the registers read as follows:
  - status-1 (index 0x25) = 0x2100, with transmit-ready in bit 13 and receive-data-start in bit 8.
  - status-2 (index 0x26) = 0x4028, with transmit-FIFO-empty in bit 14, carrier-detect-in in bit 5 and transmit-complete in bit 3.
  - test (index 0x2D) = 0x0060, with transmitter-empty in bit 6 and receiver-empty in bit 5.
  - receive data (index 0x00) = 0x4000, the error marker in bit 14.
  - control-1 (index 0x20) = 0x0001.
  - control-2 (index 0x21) = 0x0001.
  - irq, tx_valid and rx_ready are 0, 0 and 1.
- R2: A read request returns on bus_rdata at the clock edge that samples it, so the data is valid one cycle after the request. The register is selected by bus_addr[11:2].
- R3: Control-1 (0x20), control-3 (0x22), FIFO control (0x24), baud modulator (0x2A) and one-millisecond (0x2C) are read back as written, masked to the low 16 bits. A write to baud increment (0x29) is stored and read back at baud count (0x2B).
- R4: A write to transmit data (0x10) while transmit-enable (control-2 bit 2) is set does three things:
  - tx_valid goes high for exactly one cycle after the write edge, with the written low byte on tx_data.
  - Transmit-ready (status-1 bit 13) is low during that cycle.
  - Transmit-ready is high again in the cycle after.
- R5: A write to transmit data while transmit-enable is clear produces no tx_valid and leaves status-1 unchanged.
- R6: rx_ready is high exactly while receive-ready (status-1 bit 9) is clear. An accepted character does three things:
  - sets receive-ready;
  - sets receive-data-ready (status-2 bit 0);
  - clears receive-empty (test bit 5).
  Input offered while full is dropped.
- R7: A read of receive data (0x00) returns a 16-bit word, with the character-ready marker in bit 15 and the character in bits 7:0. If the buffer is full, the read also clears receive-ready and receive-data-ready and sets receive-empty. A read of an empty buffer returns the last word and changes nothing.
- R8: A break event is stored as a received word with the break flag (bit 10) and the character-ready marker set, and data 0, giving 0x8400.
- R9: irq is high when either of these holds:
  - receive-ready and control-1 bit 9 are both set;
  - transmit-ready and control-1 bit 13 are both set, and the transmit-empty gate (control-1 bit 6) is set.
- R10: A write to status-1 or status-2 clears only those written-one bits that lie in a fixed clearable mask: 0xD4F0 for status-1 and 0x9B96 for status-2. Receive-ready, transmit-ready and the reset-time flags are outside the masks and stay unchanged.
- R11: A write to control-2 with bit 0 at zero is a soft reset. It does the following:
  - returns both status registers, the test register and the receive buffer to their reset values;
  - cancels a pending strobe;
  - stores the written value in control-2.
- R12: Reads of control-4 (0x23), baud increment (0x29) and unmapped indices return 0. Writes to control-4, test and unmapped indices change nothing that can be read back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Register access request for one cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address; bits 11:2 select the register |
| bus_wdata | input | 32 | Write data; low 16 bits used |
| bus_rdata | output | 32 | Registered read data |
| tx_valid | output | 1 | One-cycle strobe carrying a character to transmit |
| tx_data | output | 8 | Character to transmit |
| rx_valid | input | 1 | Received character offered |
| rx_data | input | 8 | Received character |
| rx_break | input | 1 | Break condition offered |
| rx_ready | output | 1 | Receive holding register can accept |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume the following about the inputs:
- A soft reset never coincides with an accepted character unless it wins.
- Register accesses last one cycle, with word-aligned byte addresses.
- rx_valid and rx_break are single-cycle offers that the character side may drop when rx_ready is low.

The stimulus always drives these inputs at the falling edge and holds each request for exactly one cycle. It never offers a character in the same cycle as a control-2 write, and it offers a second character only while the buffer is full, to show that it is dropped.

// File: rtl/sercon_pkg.sv
package sercon_pkg;
  parameter int ADDR_W = 12;
  parameter int DATA_W = 32;
  parameter int REG_W  = 16;
  parameter int CHAR_W = 8;
  localparam int IDX_W = ADDR_W - 2;

  // Register word indices (bus_addr >> 2); software decodes these
  localparam logic [IDX_W-1:0] IDX_RXD  = 10'h000;
  localparam logic [IDX_W-1:0] IDX_TXD  = 10'h010;
  localparam logic [IDX_W-1:0] IDX_C1   = 10'h020;
  localparam logic [IDX_W-1:0] IDX_C2   = 10'h021;
  localparam logic [IDX_W-1:0] IDX_C3   = 10'h022;
  localparam logic [IDX_W-1:0] IDX_C4   = 10'h023;
  localparam logic [IDX_W-1:0] IDX_FCTL = 10'h024;
  localparam logic [IDX_W-1:0] IDX_S1   = 10'h025;
  localparam logic [IDX_W-1:0] IDX_S2   = 10'h026;
  localparam logic [IDX_W-1:0] IDX_BINC = 10'h029;
  localparam logic [IDX_W-1:0] IDX_BMOD = 10'h02A;
  localparam logic [IDX_W-1:0] IDX_BCNT = 10'h02B;
  localparam logic [IDX_W-1:0] IDX_MS   = 10'h02C;
  localparam logic [IDX_W-1:0] IDX_TST  = 10'h02D;

  // Bit positions
  localparam int S1_TRDY = 13, S1_RRDY = 9;
  localparam int S2_RDR = 0;
  localparam int T_RXEMPTY = 5, T_TXEMPTY = 6;
  localparam int C1_TXMPTYEN = 6, C1_RRDYEN = 9, C1_TRDYEN = 13;
  localparam int C2_SRSTN = 0, C2_TXEN = 2;
  localparam int RX_CHARRDY = 15, RX_ERR = 14, RX_BRK = 10;

  // Reset values and clearable masks
  localparam logic [REG_W-1:0] S1_RST  = 16'h0100; // stored part, flags added on read
  localparam logic [REG_W-1:0] S2_RST  = 16'h4028;
  localparam logic [REG_W-1:0] S1_CLR  = 16'hD4F0;
  localparam logic [REG_W-1:0] S2_CLR  = 16'h9B96;
  localparam logic [REG_W-1:0] C1_RST  = 16'h0001;
  localparam logic [REG_W-1:0] C2_RST  = 16'h0001;
  localparam logic [REG_W-1:0] RXW_RST = 16'h4000;

  function automatic logic irq_calc(input logic [REG_W-1:0] s1, input logic [REG_W-1:0] c1);
    logic [REG_W-1:0] m;
    m = '0;
    m[S1_TRDY] = 1'b1;
    m[S1_RRDY] = 1'b1;
    m = m & s1 & c1;
    if (!c1[C1_TXMPTYEN]) m[S1_TRDY] = 1'b0;
    return |m;
  endfunction

  function automatic logic [REG_W-1:0] rx_word(input logic [CHAR_W-1:0] ch, input logic brk);
    logic [REG_W-1:0] w;
    w = '0;
    w[RX_CHARRDY] = 1'b1;
    w[RX_BRK] = brk;
    w[CHAR_W-1:0] = brk ? '0 : ch;
    return w;
  endfunction
endpackage

// File: rtl/sercon_w1c.sv
module sercon_w1c #(
  parameter int W = 16,
  parameter logic [W-1:0] RST = '0,
  parameter logic [W-1:0] CLR = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= RST;
    else if (soft_rst) q <= RST;
    else if (wr)       q <= q & ~(wdata & CLR);
  end
endmodule

// File: rtl/sercon_txhold.sv
module sercon_txhold #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          send,
  input  logic [CW-1:0] din,
  output logic          tx_valid,
  output logic [CW-1:0] tx_data,
  output logic          trdy
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
      trdy     <= 1'b1;
    end else if (soft_rst) begin
      tx_valid <= 1'b0;
      trdy     <= 1'b1;
    end else if (send) begin
      tx_valid <= 1'b1;
      tx_data  <= din;
      trdy     <= 1'b0;
    end else begin
      tx_valid <= 1'b0;
      trdy     <= 1'b1;
    end
  end
endmodule

// File: rtl/sercon_rxhold.sv
module sercon_rxhold
  import sercon_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_data,
  input  logic              in_brk,
  input  logic              take,
  output logic              ready,
  output logic              full,
  output logic [REG_W-1:0]  word
);
  logic accept;
  assign ready  = !full;
  assign accept = ready && (in_valid || in_brk);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      word <= RXW_RST;
    end else if (soft_rst) begin
      full <= 1'b0;
      word <= RXW_RST;
    end else if (accept) begin
      full <= 1'b1;
      word <= rx_word(in_data, in_brk);
    end else if (take && full) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/sercon_regs.sv
module sercon_regs
  import sercon_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              tx_valid,
  output logic [CHAR_W-1:0] tx_data,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_data,
  input  logic              rx_break,
  output logic              rx_ready,
  output logic              irq
);
  logic [IDX_W-1:0] word_idx;
  logic [REG_W-1:0] wval;
  logic wr, rd, soft_rst, tx_send, rx_take, trdy, rx_full;
  logic [REG_W-1:0] ctrl1_q, ctrl2_q, ctrl3_q, fctl_q, bmod_q, bcnt_q, ms_q;
  logic [REG_W-1:0] s1_q, s2_q, s1_view, s2_view, tst_view, rx_word_q;
  logic [REG_W-1:0] rd_val;
  logic unused_bits;

  assign word_idx = bus_addr[ADDR_W-1:2];
  assign wval     = bus_wdata[REG_W-1:0];
  assign unused_bits = ^{bus_wdata[DATA_W-1:REG_W], bus_addr[1:0]};
  assign wr = bus_req && bus_we;
  assign rd = bus_req && !bus_we;
  assign soft_rst = wr && (word_idx == IDX_C2) && !wval[C2_SRSTN];
  assign tx_send  = wr && (word_idx == IDX_TXD) && ctrl2_q[C2_TXEN];
  assign rx_take  = rd && (word_idx == IDX_RXD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl1_q <= C1_RST;
      ctrl2_q <= C2_RST;
      ctrl3_q <= '0;
      fctl_q  <= '0;
      bmod_q  <= '0;
      bcnt_q  <= '0;
      ms_q    <= '0;
    end else if (wr) begin
      case (word_idx)
        IDX_C1:   ctrl1_q <= wval;
        IDX_C2:   ctrl2_q <= wval;
        IDX_C3:   ctrl3_q <= wval;
        IDX_FCTL: fctl_q  <= wval;
        IDX_BINC: bcnt_q  <= wval;
        IDX_BMOD: bmod_q  <= wval;
        IDX_MS:   ms_q    <= wval;
        default: ;
      endcase
    end
  end

  sercon_w1c #(.W(REG_W), .RST(S1_RST), .CLR(S1_CLR)) u_s1 (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .wr(wr && word_idx == IDX_S1), .wdata(wval), .q(s1_q));

  sercon_w1c #(.W(REG_W), .RST(S2_RST), .CLR(S2_CLR)) u_s2 (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .wr(wr && word_idx == IDX_S2), .wdata(wval), .q(s2_q));

  sercon_txhold #(.CW(CHAR_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .send(tx_send),
    .din(wval[CHAR_W-1:0]), .tx_valid(tx_valid), .tx_data(tx_data), .trdy(trdy));

  sercon_rxhold u_rx (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .in_valid(rx_valid),
    .in_data(rx_data), .in_brk(rx_break), .take(rx_take), .ready(rx_ready),
    .full(rx_full), .word(rx_word_q));

  always_comb begin
    s1_view = s1_q;
    s1_view[S1_TRDY] = trdy;
    s1_view[S1_RRDY] = rx_full;
    s2_view = s2_q;
    s2_view[S2_RDR] = rx_full;
    tst_view = '0;
    tst_view[T_RXEMPTY] = !rx_full;
    tst_view[T_TXEMPTY] = trdy;
  end

  always_comb begin
    case (word_idx)
      IDX_RXD:  rd_val = rx_word_q;
      IDX_C1:   rd_val = ctrl1_q;
      IDX_C2:   rd_val = ctrl2_q;
      IDX_C3:   rd_val = ctrl3_q;
      IDX_FCTL: rd_val = fctl_q;
      IDX_S1:   rd_val = s1_view;
      IDX_S2:   rd_val = s2_view;
      IDX_BMOD: rd_val = bmod_q;
      IDX_BCNT: rd_val = bcnt_q;
      IDX_MS:   rd_val = ms_q;
      IDX_TST:  rd_val = tst_view;
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  bus_rdata <= '0;
    else if (rd) bus_rdata <= {{(DATA_W-REG_W){1'b0}}, rd_val};
  end

  assign irq = irq_calc(s1_view, ctrl1_q);
endmodule

// File: rtl/sercon_chk.sv
module sercon_chk
  import sercon_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             bus_req,
  input logic             bus_we,
  input logic [IDX_W-1:0] word_idx,
  input logic             soft_rst,
  input logic             tx_send,
  input logic             c1_rrdyen,
  input logic             c1_trdyen,
  input logic             c2_txen,
  input logic             tx_valid,
  input logic             trdy,
  input logic             rx_full,
  input logic             rx_ready,
  input logic             rx_valid,
  input logic             rx_break,
  input logic             irq
);
  a_r4_trdy_low: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !trdy);
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_send |=> !tx_valid);
  a_r5_no_send_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && word_idx == IDX_TXD && !c2_txen) |=> !tx_valid);
  a_r6_ready_gate: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |-> !rx_ready);
  a_r6_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
    ((rx_valid || rx_break) && rx_ready && !soft_rst) |=> rx_full);
  a_r7_read_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && word_idx == IDX_RXD && rx_full) |=> !rx_full);
  a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !(c1_rrdyen || c1_trdyen) |-> !irq);
  a_r11_soft_clears: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!rx_full && trdy && !tx_valid));
endmodule

bind sercon_regs sercon_chk i_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
  .word_idx(word_idx), .soft_rst(soft_rst), .tx_send(tx_send),
  .c1_rrdyen(ctrl1_q[sercon_pkg::C1_RRDYEN]), .c1_trdyen(ctrl1_q[sercon_pkg::C1_TRDYEN]),
  .c2_txen(ctrl2_q[sercon_pkg::C2_TXEN]), .tx_valid(tx_valid), .trdy(trdy),
  .rx_full(rx_full), .rx_ready(rx_ready), .rx_valid(rx_valid),
  .rx_break(rx_break), .irq(irq));

// File: tb/test_sercon_regs.sv
module test_sercon_regs;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_req = 0, bus_we = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic tx_valid, rx_ready, irq;
  logic [7:0] tx_data, rx_data = '0;
  logic rx_valid = 0, rx_break = 0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sercon_regs i_sercon_regs (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_break(rx_break), .rx_ready(rx_ready), .irq(irq));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [9:0] idx, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = {idx, 2'b00}; bus_wdata = d;
    @(negedge clk);
    bus_req = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [9:0] idx, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1; bus_we = 0; bus_addr = {idx, 2'b00};
    @(negedge clk);
    bus_req = 0;
    d = bus_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [9:0] idx, input logic [31:0] exp);
    logic [31:0] d;
    rd(idx, d);
    chk(req, d, exp);
  endtask

  task automatic offer(input logic [7:0] ch, input logic brk);
    @(negedge clk);
    rx_valid = !brk; rx_break = brk; rx_data = ch;
    @(negedge clk);
    rx_valid = 0; rx_break = 0;
  endtask

  task automatic t_reset;
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 tx_valid", {31'b0, tx_valid}, 0);
    chk("R1 rx_ready", {31'b0, rx_ready}, 1);
    rd_chk("R1 status1", 10'h25, 32'h2100);
    rd_chk("R1 status2", 10'h26, 32'h4028);
    rd_chk("R1 test", 10'h2D, 32'h0060);
    rd_chk("R1 rxdata", 10'h00, 32'h4000);
    rd_chk("R1 ctrl1", 10'h20, 32'h0001);
    rd_chk("R1 ctrl2", 10'h21, 32'h0001);
  endtask

  task automatic t_storage;
    wr(10'h22, 32'hABCD1234); rd_chk("R3 ctrl3 masked", 10'h22, 32'h1234);
    wr(10'h24, 32'h00000801); rd_chk("R3 fifo ctrl", 10'h24, 32'h0801);
    wr(10'h2A, 32'hFFFF5A5A); rd_chk("R3 baud mod", 10'h2A, 32'h5A5A);
    wr(10'h2C, 32'h000003E8); rd_chk("R3 one ms", 10'h2C, 32'h03E8);
    wr(10'h29, 32'h0000BEEF); rd_chk("R3 baud incr to count", 10'h2B, 32'hBEEF);
    rd_chk("R12 baud incr reads 0", 10'h29, 0);
    wr(10'h23, 32'hFFFF); rd_chk("R12 ctrl4 reads 0", 10'h23, 0);
    wr(10'h2D, 32'hFFFF); rd_chk("R12 test write ignored", 10'h2D, 32'h0060);
    wr(10'h3F, 32'hFFFF); rd_chk("R12 unmapped reads 0", 10'h3F, 0);
    rd_chk("R2 ctrl3 unchanged by others", 10'h22, 32'h1234);
  endtask

  task automatic t_tx;
    wr(10'h10, 32'h55);
    chk("R5 no strobe without enable", {31'b0, tx_valid}, 0);
    rd_chk("R5 status1 unchanged", 10'h25, 32'h2100);
    wr(10'h21, 32'h0007);
    wr(10'h20, 32'h2041);
    chk("R9 irq on transmit-ready", {31'b0, irq}, 1);
    wr(10'h10, 32'h1A5);
    chk("R4 strobe", {31'b0, tx_valid}, 1);
    chk("R4 byte", {24'b0, tx_data}, 32'hA5);
    chk("R4 trdy low drops irq", {31'b0, irq}, 0);
    @(negedge clk);
    chk("R4 strobe one cycle", {31'b0, tx_valid}, 0);
    chk("R4 trdy back", {31'b0, irq}, 1);
    wr(10'h20, 32'h2001);
    chk("R9 transmit-empty gate clear", {31'b0, irq}, 0);
    wr(10'h20, 32'h0201);
  endtask

  task automatic t_rx;
    chk("R9 idle irq", {31'b0, irq}, 0);
    offer(8'h3C, 0);
    chk("R6 full drops ready", {31'b0, rx_ready}, 0);
    chk("R9 irq on receive-ready", {31'b0, irq}, 1);
    rd_chk("R6 status1 rrdy", 10'h25, 32'h2300);
    rd_chk("R6 status2 rdr", 10'h26, 32'h4029);
    rd_chk("R6 test rx not empty", 10'h2D, 32'h0040);
    offer(8'h77, 0);
    rd_chk("R7 read char", 10'h00, 32'h803C);
    chk("R7 ready again", {31'b0, rx_ready}, 1);
    chk("R7 irq cleared", {31'b0, irq}, 0);
    rd_chk("R7 empty read no change", 10'h00, 32'h803C);
    rd_chk("R7 status1 after", 10'h25, 32'h2100);
    rd_chk("R7 status2 after", 10'h26, 32'h4028);
    offer(8'h99, 1);
    rd_chk("R8 break word", 10'h00, 32'h8400);
  endtask

  task automatic t_w1c;
    wr(10'h25, 32'hFFFF); rd_chk("R10 status1 protected", 10'h25, 32'h2100);
    wr(10'h26, 32'hFFFF); rd_chk("R10 status2 protected", 10'h26, 32'h4028);
    offer(8'h11, 0);
    wr(10'h25, 32'hFFFF); rd_chk("R10 rrdy not clearable", 10'h25, 32'h2300);
    wr(10'h26, 32'hFFFF); rd_chk("R10 rdr not clearable", 10'h26, 32'h4029);
  endtask

  task automatic t_soft;
    wr(10'h21, 32'h0006);
    chk("R11 ready after soft reset", {31'b0, rx_ready}, 1);
    rd_chk("R11 status1", 10'h25, 32'h2100);
    rd_chk("R11 status2", 10'h26, 32'h4028);
    rd_chk("R11 test", 10'h2D, 32'h0060);
    rd_chk("R11 rx word", 10'h00, 32'h4000);
    rd_chk("R11 ctrl2 stored", 10'h21, 32'h0006);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_storage();
    t_tx();
    t_rx();
    t_w1c();
    t_soft();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule